// File: doc/BRIEF.md
# Stereo Transmit Sample Queue

This block sits between a register-mapped write path and an audio serializer. It holds up to eight stereo sample pairs in arrival order. Software loads a pair in two writes: a write to the left port parks the left sample in a staging register, and a following write to the right port joins the parked left sample with the new right sample and queues the pair. The serializer pulls one pair per frame. A pull that finds the queue empty gets silence (a zero pair) and leaves a sticky underflow flag behind.

Two interrupts are provided. The level interrupt tells software to refill. It fires either at half empty or only when completely drained, depending on a select pin. The underflow interrupt reports the sticky flag when its enable is set. A run enable gates the serializer side. Dropping it discards every queued pair and any parked left sample, so no left/right misalignment survives a restart. While the enable is low, software may still preload pairs before the enable is raised.

Write strobes carry no back-pressure. Software polls `full`, and a pair completed while full is dropped. The pull side has no stall either: each `pull_req` is answered one cycle later with `pull_valid` and a pair, which may be the zero pair.

Top module: `stereo_tx_fifo`

## Requirements
- R1: The queue holds 8 pairs; `full` is 1 exactly when 8 are held, and a pair completed while full is dropped, leaving the held contents unchanged.
- R2: A left-port write parks its sample (a later left write replaces it); a right-port write with a parked sample queues the pair {parked left, right} and clears the parking.
- R3: A right-port write with no parked left sample is ignored and changes nothing.
- R4: A `pull_req` while enabled and not empty answers in the next cycle with `pull_valid`=1 and the oldest pair, and removes it; pairs leave in the order they were queued.
- R5: A `pull_req` while enabled and empty answers with a zero pair and sets `udf_sticky`, which stays set until the cycle after `run_en` rises.
- R6: `irq_udf` equals `udf_sticky` AND `udf_ie`.
- R7: While enabled, `irq_lvl` is 1 when `lvl_sel`=0 and the level is 4 or less, or when `lvl_sel`=1 and the level is 0; otherwise it is 0.
- R8: While `run_en` is 0, a pull returns a zero pair, removes nothing and sets no underflow, `irq_lvl` is 0, and complete pairs are still queued.
- R9: The clock edge at which `run_en` is first seen low after being high discards all queued pairs and the parked left sample; writes presented in that cycle are lost.
- R10: After reset the level is 0, `empty`=1, `full`=0, and all interrupts, `pull_valid` and `udf_sticky` are 0.
- R11: `empty` is 1 exactly when the level is 0, and `level` reports the number of queued pairs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Run enable; its falling edge flushes the queue |
| lvl_sel | input | 1 | Level interrupt point: 0 half empty, 1 empty |
| udf_ie | input | 1 | Underflow interrupt enable |
| wr_left | input | 1 | Left-port write strobe |
| wr_right | input | 1 | Right-port write strobe |
| wr_data | input | 24 | Sample for either write port |
| pull_req | input | 1 | Serializer request for one pair |
| pull_valid | output | 1 | Answer to the previous cycle's request |
| pull_left | output | 24 | Left sample of the answer |
| pull_right | output | 24 | Right sample of the answer |
| level | output | 4 | Number of queued pairs |
| full | output | 1 | Queue holds 8 pairs |
| empty | output | 1 | Queue holds no pairs |
| irq_lvl | output | 1 | Refill interrupt |
| irq_udf | output | 1 | Underflow interrupt |
| udf_sticky | output | 1 | Sticky underflow flag |

## Verification
The bench writes pairs with distinct left and right values, so a swap or a shift by one sample shows up in the pulled data. Ordered writes followed by ordered pulls confirm arrival order. Fills to capacity and then beyond confirm that the ninth pair never appears. Orphan right writes and doubled left writes separate the staging rules from the queue itself. A sweep of the level from 0 to 8 and back, under both select settings, locates the exact interrupt boundaries. Disabling with a parked left sample, followed by preloading while disabled, distinguishes the flush from the hold.

// File: rtl/stfifo_pkg.sv
package stfifo_pkg;
  parameter int unsigned SMP_W = 24;

  typedef struct packed {
    logic [SMP_W-1:0] l;
    logic [SMP_W-1:0] r;
  } pair_t;
endpackage

// File: rtl/stfifo_stage.sv
module stfifo_stage
  import stfifo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_left,
  input  logic             wr_right,
  input  logic [SMP_W-1:0] wr_data,
  input  logic             full,
  output logic             push,
  output pair_t            push_pair
);
  logic [SMP_W-1:0] left_q;
  logic             left_v;

  // a right write consumes the parked left; both are lost when full
  assign push      = wr_right & left_v & ~full & ~flush;
  assign push_pair = '{l: left_q, r: wr_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
      left_v <= 1'b0;
    end else if (flush) begin
      left_v <= 1'b0;
    end else begin
      if (wr_right) left_v <= 1'b0;
      if (wr_left) begin
        left_q <= wr_data;
        left_v <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/stfifo_ring.sv
module stfifo_ring
  import stfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned LW = AW + 1
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  pair_t         push_pair,
  input  logic          pop,
  output pair_t         head,
  output logic [LW-1:0] level
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  pair_t         mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] level_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_pair;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_q <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      level_q <= level_q + {{(LW-1){1'b0}}, push} - {{(LW-1){1'b0}}, pop};
    end
  end

  assign head  = mem[rd_ptr];
  assign level = level_q;
endmodule

// File: rtl/stfifo_irq.sv
module stfifo_irq #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned LW = $clog2(DEPTH) + 1
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          run_rise,
  input  logic          lvl_sel,
  input  logic          udf_ie,
  input  logic          udf_evt,
  input  logic [LW-1:0] level,
  output logic          irq_lvl,
  output logic          irq_udf,
  output logic          udf_sticky
);
  localparam logic [LW-1:0] HALF = LW'(DEPTH / 2);

  logic sticky_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sticky_q <= 1'b0;
    else        sticky_q <= (sticky_q & ~run_rise) | udf_evt;
  end

  assign irq_lvl    = run_en & (lvl_sel ? (level == '0) : (level <= HALF));
  assign irq_udf    = sticky_q & udf_ie;
  assign udf_sticky = sticky_q;
endmodule

// File: rtl/stereo_tx_fifo.sv
module stereo_tx_fifo
  import stfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned LW = $clog2(DEPTH) + 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             lvl_sel,
  input  logic             udf_ie,
  input  logic             wr_left,
  input  logic             wr_right,
  input  logic [SMP_W-1:0] wr_data,
  input  logic             pull_req,
  output logic             pull_valid,
  output logic [SMP_W-1:0] pull_left,
  output logic [SMP_W-1:0] pull_right,
  output logic [LW-1:0]    level,
  output logic             full,
  output logic             empty,
  output logic             irq_lvl,
  output logic             irq_udf,
  output logic             udf_sticky
);
  logic  run_q, flush, run_rise;
  logic  push, pop, udf_evt;
  pair_t push_pair, head;
  logic [LW-1:0] lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_en;
  end

  assign flush    = run_q & ~run_en;
  assign run_rise = run_en & ~run_q;
  assign empty    = (lvl == '0);
  assign full     = (lvl == LW'(DEPTH));
  assign pop      = pull_req & run_en & ~empty;
  assign udf_evt  = pull_req & run_en & empty;
  assign level    = lvl;

  stfifo_stage u_stage (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_left(wr_left), .wr_right(wr_right), .wr_data(wr_data),
    .full(full), .push(push), .push_pair(push_pair)
  );

  stfifo_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(push), .push_pair(push_pair), .pop(pop),
    .head(head), .level(lvl)
  );

  stfifo_irq #(.DEPTH(DEPTH)) u_irq (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .run_rise(run_rise),
    .lvl_sel(lvl_sel), .udf_ie(udf_ie), .udf_evt(udf_evt), .level(lvl),
    .irq_lvl(irq_lvl), .irq_udf(irq_udf), .udf_sticky(udf_sticky)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pull_valid <= 1'b0;
      pull_left  <= '0;
      pull_right <= '0;
    end else begin
      pull_valid <= pull_req;
      if (pull_req) begin
        pull_left  <= pop ? head.l : '0;
        pull_right <= pop ? head.r : '0;
      end
    end
  end
endmodule

// File: rtl/stfifo_chk.sv
module stfifo_chk
  import stfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned LW = $clog2(DEPTH) + 1
)(
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             udf_ie,
  input logic             pull_req,
  input logic             pull_valid,
  input logic [SMP_W-1:0] pull_left,
  input logic [SMP_W-1:0] pull_right,
  input logic [LW-1:0]    level,
  input logic             full,
  input logic             empty,
  input logic             irq_lvl,
  input logic             irq_udf,
  input logic             udf_sticky
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH)); // R1
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && run_en && !pull_req) |=> full); // R1
  AST_FULL_EMPTY_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R11
  AST_ANSWER_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    pull_req |=> pull_valid); // R4
  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> (level <= $past(level) + 1'b1)); // R4
  AST_DRY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_req && run_en && empty) |=> (pull_left == '0 && pull_right == '0 && udf_sticky)); // R5
  AST_UDF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_udf |-> (udf_ie && udf_sticky)); // R6
  AST_LVL_AT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && empty) |-> irq_lvl); // R7
  AST_LVL_QUIET_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !irq_lvl); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_req && !run_en) |=> (pull_left == '0 && pull_right == '0)); // R8
  AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !irq_lvl); // R8
  AST_FLUSH_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_en) |=> (level <= 1)); // R9
endmodule

bind stereo_tx_fifo stfifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .udf_ie(udf_ie),
  .pull_req(pull_req), .pull_valid(pull_valid),
  .pull_left(pull_left), .pull_right(pull_right),
  .level(level), .full(full), .empty(empty),
  .irq_lvl(irq_lvl), .irq_udf(irq_udf), .udf_sticky(udf_sticky)
);

// File: tb/test_stereo_tx_fifo.sv
module test_stereo_tx_fifo;
  import stfifo_pkg::*;
  localparam int DEPTH = 8;
  localparam int LW = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, run_en = 1'b0, lvl_sel = 1'b0, udf_ie = 1'b0;
  logic wr_left = 1'b0, wr_right = 1'b0, pull_req = 1'b0;
  logic [SMP_W-1:0] wr_data = '0;
  logic pull_valid, full, empty, irq_lvl, irq_udf, udf_sticky;
  logic [SMP_W-1:0] pull_left, pull_right;
  logic [LW-1:0] level;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  stereo_tx_fifo #(.DEPTH(DEPTH)) i_stereo_tx_fifo (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .lvl_sel(lvl_sel), .udf_ie(udf_ie),
    .wr_left(wr_left), .wr_right(wr_right), .wr_data(wr_data),
    .pull_req(pull_req), .pull_valid(pull_valid),
    .pull_left(pull_left), .pull_right(pull_right),
    .level(level), .full(full), .empty(empty),
    .irq_lvl(irq_lvl), .irq_udf(irq_udf), .udf_sticky(udf_sticky)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // every task starts and ends just after a falling edge
  task automatic op_left(input logic [SMP_W-1:0] d);
    wr_left = 1'b1; wr_data = d;
    @(negedge clk);
    wr_left = 1'b0;
  endtask

  task automatic op_right(input logic [SMP_W-1:0] d);
    wr_right = 1'b1; wr_data = d;
    @(negedge clk);
    wr_right = 1'b0;
  endtask

  task automatic op_pair(input logic [SMP_W-1:0] l, input logic [SMP_W-1:0] r);
    op_left(l);
    op_right(r);
  endtask

  task automatic pull_check(input string tag, input logic [SMP_W-1:0] l, input logic [SMP_W-1:0] r);
    pull_req = 1'b1;
    @(negedge clk);
    pull_req = 1'b0;
    check({tag, " valid"}, 32'(pull_valid), 32'd1);
    check({tag, " left"},  32'(pull_left),  32'(l));
    check({tag, " right"}, 32'(pull_right), 32'(r));
  endtask

  task automatic set_run(input logic b);
    run_en = b;
    @(negedge clk);
  endtask

  task automatic restart();
    set_run(1'b0);
    set_run(1'b1);
  endtask

  task automatic t_reset();
    check("R10 level", 32'(level), 32'd0);
    check("R10 empty", 32'(empty), 32'd1);
    check("R10 full", 32'(full), 32'd0);
    check("R10 irq_lvl", 32'(irq_lvl), 32'd0);
    check("R10 irq_udf", 32'(irq_udf), 32'd0);
    check("R10 pull_valid", 32'(pull_valid), 32'd0);
    check("R10 sticky", 32'(udf_sticky), 32'd0);
  endtask

  task automatic t_order();
    restart();
    op_pair(24'h000111, 24'h000AAA);
    op_pair(24'h000222, 24'h000BBB);
    op_pair(24'h000333, 24'h000CCC);
    check("R11 level 3", 32'(level), 32'd3);
    check("R11 not empty", 32'(empty), 32'd0);
    pull_check("R4 first", 24'h000111, 24'h000AAA);
    pull_check("R4 second", 24'h000222, 24'h000BBB);
    pull_check("R4 third", 24'h000333, 24'h000CCC);
    check("R11 empty after drain", 32'(empty), 32'd1);
    check("R4 no underflow with data", 32'(udf_sticky), 32'd0);
  endtask

  task automatic t_stage();
    restart();
    op_right(24'h000055);
    check("R3 orphan right ignored", 32'(level), 32'd0);
    op_left(24'h000001);
    op_left(24'h000002);
    op_right(24'h000003);
    check("R2 one pair queued", 32'(level), 32'd1);
    pull_check("R2 latest left kept", 24'h000002, 24'h000003);
  endtask

  task automatic t_full();
    restart();
    for (int i = 0; i < DEPTH; i++) begin
      if (i == DEPTH - 1) check("R1 not full at 7", 32'(full), 32'd0);
      op_pair(SMP_W'(32'h100 + i), SMP_W'(32'h200 + i));
    end
    check("R1 full at 8", 32'(full), 32'd1);
    op_pair(24'h0000EE, 24'h0000EF);
    check("R1 level stays 8", 32'(level), 32'd8);
    for (int i = 0; i < DEPTH; i++)
      pull_check("R1 contents", SMP_W'(32'h100 + i), SMP_W'(32'h200 + i));
    pull_check("R1 dropped pair absent", 24'h0, 24'h0);
  endtask

  task automatic t_udf();
    restart();
    udf_ie = 1'b0;
    pull_check("R5 dry pull zero", 24'h0, 24'h0);
    check("R5 sticky set", 32'(udf_sticky), 32'd1);
    check("R6 masked", 32'(irq_udf), 32'd0);
    udf_ie = 1'b1;
    @(negedge clk);
    check("R6 unmasked", 32'(irq_udf), 32'd1);
    set_run(1'b0);
    check("R5 sticky survives disable", 32'(udf_sticky), 32'd1);
    set_run(1'b1);
    check("R5 sticky cleared by enable", 32'(udf_sticky), 32'd0);
    check("R6 irq cleared", 32'(irq_udf), 32'd0);
    udf_ie = 1'b0;
  endtask

  task automatic t_irq();
    restart();
    lvl_sel = 1'b0;
    @(negedge clk);
    check("R7 half mode level 0", 32'(irq_lvl), 32'd1);
    for (int i = 1; i <= DEPTH; i++) begin
      op_pair(SMP_W'(i), SMP_W'(i));
      check($sformatf("R7 half mode level %0d", i), 32'(irq_lvl), 32'(i <= DEPTH / 2));
    end
    lvl_sel = 1'b1;
    @(negedge clk);
    for (int i = DEPTH - 1; i >= 0; i--) begin
      pull_check("R7 drain", SMP_W'(DEPTH - i), SMP_W'(DEPTH - i));
      check($sformatf("R7 empty mode level %0d", i), 32'(irq_lvl), 32'(i == 0));
    end
    op_pair(24'h00000F, 24'h0000F0);
    check("R7 deasserts above threshold", 32'(irq_lvl), 32'd0);
  endtask

  task automatic t_disabled();
    restart();
    op_pair(24'h000001, 24'h000002);
    op_pair(24'h000003, 24'h000004);
    op_left(24'h000077);
    set_run(1'b0);
    check("R9 flushed", 32'(level), 32'd0);
    check("R8 irq off while idle", 32'(irq_lvl), 32'd0);
    set_run(1'b1);
    op_right(24'h000099);
    check("R9 parked left discarded", 32'(level), 32'd0);
    set_run(1'b0);
    op_pair(24'h0000A1, 24'h0000B1);
    op_pair(24'h0000A2, 24'h0000B2);
    check("R8 preload accepted", 32'(level), 32'd2);
    pull_check("R8 idle pull zero", 24'h0, 24'h0);
    check("R8 idle pull keeps level", 32'(level), 32'd2);
    check("R8 idle pull no underflow", 32'(udf_sticky), 32'd0);
    set_run(1'b1);
    pull_check("R8 preload delivered", 24'h0000A1, 24'h0000B1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_stage();
    t_full();
    t_udf();
    t_irq();
    t_disabled();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule